// File: doc/BRIEF.md
# Synchronous Exception Entry Sequencer

This block performs the state-saving step of a processor's entry into a synchronous exception. The core presents a request with an event code and the program counter of the faulting instruction. Alongside the request it drives its live status word, its stack-pointer register and its vector base register. In the clock edge that accepts the request, the block does all of the following at once:
- copies the status word, the faulting PC and the stack pointer into three shadow registers;
- records the event code;
- produces the new status word with the block, privileged-mode and register-bank bits forced to 1;
- produces the handler address.

A one-cycle `done` pulse marks the cycle in which the new status word and handler address are valid for the core to load.

The request side is a valid/ready stream. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the core must hold `req_valid` and the request fields stable, but no completion ever comes back. `req_ready` is high from reset and drops only when the block enters its fatal state. It then stays low until reset. The block holds no request buffer, so there is no back-pressure other than the fatal state, and requests may be accepted on consecutive edges.

A request is fatal in two cases: it arrives while the incoming status word already has its block bit set, or its code is not a synchronous class. A fatal request raises a sticky `fatal` output, performs no entry and freezes every register the block owns until reset.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `done` and `fatal` are 0, `req_ready` is 1, and `new_pc`, `sr_out`, `saved_sr`, `saved_pc`, `saved_sp` and `evt_code` are all zero.
- R2: An accepted request that is legal raises `done` in the following cycle and writes its code to `evt_code`. `done` lasts exactly one cycle unless another legal request is accepted on that edge.
- R3: On a legal entry, `saved_sr` takes `cur_sr`, `saved_pc` takes `req_pc`, and `saved_sp` takes `cur_sp`, all as sampled at the accepting edge.
- R4: On a legal entry, `sr_out` equals `cur_sr` with bit 28 (block), bit 29 (register bank) and bit 30 (privileged mode) set to 1. Every other bit is copied unchanged.
- R5: On a legal entry, `new_pc` is `vbr + 0x400` when the code is 0x040 (TLB miss on read) or 0x060 (TLB miss on write). For every other legal code it is `vbr + 0x100`. The sum wraps modulo 2^32.
- R6: A code is legal only if it is in the range 0x040 to 0x1A0 inclusive, or is 0x1E0 (user break), 0x800 (FPU disabled) or 0x820 (FPU disabled in delay slot). An accepted request with any other code sets `fatal` in the next cycle, does not raise `done`, and changes no output register.
- R7: An accepted request whose `cur_sr` bit 28 is 1 sets `fatal` in the next cycle, does not raise `done`, and changes no output register.
- R8: Once `fatal` is 1, it stays 1 and `req_ready` stays 0 until reset. `done` stays 0, and further requests are not accepted and change no output register.
- R9: Legal requests accepted on consecutive edges each commit. `done` stays high across both cycles, and the outputs show the second request's values after the second edge.
- R10: With `req_valid` low, changes on the request and state inputs leave every output register unchanged and `done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Request can be accepted (low only when fatal) |
| req_code | input | CODE_W | Event code of the request |
| req_pc | input | XLEN | Program counter of the faulting instruction |
| cur_sr | input | XLEN | Live status word |
| cur_sp | input | XLEN | Live stack-pointer register |
| vbr | input | XLEN | Vector base register |
| done | output | 1 | One-cycle pulse: entry committed, `new_pc`/`sr_out` valid |
| new_pc | output | XLEN | Handler address |
| sr_out | output | XLEN | Status word to load after entry |
| saved_sr | output | XLEN | Shadow copy of the status word |
| saved_pc | output | XLEN | Shadow copy of the faulting PC |
| saved_sp | output | XLEN | Shadow copy of the stack pointer |
| evt_code | output | CODE_W | Recorded event code |
| fatal | output | 1 | Sticky fatal-error flag |

## Verification
Two functions can land in the same cycle: the completion pulse of one entry and the acceptance of the next request. The bench provokes this by holding `req_valid` high across two edges, with new fields driven between them. It checks that `done` is still high after the first edge and again after the second. It also checks that every shadow register, `sr_out` and `new_pc` then carry the second request's values rather than a mix of the two. A fatal request is likewise issued right after a committed entry, to show that the earlier entry's values survive the error.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // Status word bit positions forced at entry; the core decodes these.
  localparam int SR_BLOCK_BIT = 28;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_PRIV_BIT  = 30;

  // Legal synchronous code classes.
  localparam int unsigned SYNC_RANGE_LO = 32'h040;
  localparam int unsigned SYNC_RANGE_HI = 32'h1A0;
  localparam int unsigned CODE_TLB_RD   = 32'h040;
  localparam int unsigned CODE_TLB_WR   = 32'h060;
  localparam int          N_LONE_CODES  = 3;
  localparam int unsigned LONE_CODES [N_LONE_CODES] = '{32'h1E0, 32'h800, 32'h820};

  // Handler offsets from the vector base.
  localparam int unsigned OFS_TLB_MISS = 32'h400;
  localparam int unsigned OFS_GENERAL  = 32'h100;

  typedef struct packed {
    logic legal;
    logic tlb_miss;
  } exc_class_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] code,
  output exc_class_t        cls
);
  logic [31:0]             code_ext;
  logic [N_LONE_CODES-1:0] lone_hit;
  logic                    in_range;

  assign code_ext = 32'(code);
  assign in_range = (code_ext >= SYNC_RANGE_LO) && (code_ext <= SYNC_RANGE_HI);

  for (genvar g = 0; g < N_LONE_CODES; g++) begin : g_lone
    assign lone_hit[g] = (code_ext == LONE_CODES[g]);
  end

  always_comb begin
    cls.legal    = in_range || (|lone_hit);
    cls.tlb_miss = (code_ext == CODE_TLB_RD) || (code_ext == CODE_TLB_WR);
  end

  // R5 a TLB-miss code is always legal
  always_comb begin
    tlb_legal_chk: assert (!cls.tlb_miss || cls.legal);
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] vbr,
  input  logic            tlb_miss,
  output logic [XLEN-1:0] handler_pc
);
  localparam logic [XLEN-1:0] OFS_T = XLEN'(OFS_TLB_MISS);
  localparam logic [XLEN-1:0] OFS_G = XLEN'(OFS_GENERAL);

  assign handler_pc = vbr + (tlb_miss ? OFS_T : OFS_G);
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              legal,
  input  logic [XLEN-1:0]   handler_pc,
  input  logic [CODE_W-1:0] req_code,
  input  logic [XLEN-1:0]   req_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_sp,
  output logic              done,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sp,
  output logic [CODE_W-1:0] evt_code,
  output logic              fatal
);
  localparam logic [XLEN-1:0] FORCE_MASK =
    (XLEN'(1) << SR_BLOCK_BIT) | (XLEN'(1) << SR_BANK_BIT) | (XLEN'(1) << SR_PRIV_BIT);

  logic blocked, commit, trip;

  assign blocked = cur_sr[SR_BLOCK_BIT];
  assign commit  = fire && legal && !blocked;
  assign trip    = fire && !(legal && !blocked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fatal    <= 1'b0;
      new_pc   <= '0;
      sr_out   <= '0;
      saved_sr <= '0;
      saved_pc <= '0;
      saved_sp <= '0;
      evt_code <= '0;
    end else begin
      done <= commit;
      if (trip) fatal <= 1'b1;
      if (commit) begin
        saved_sr <= cur_sr;
        saved_pc <= req_pc;
        saved_sp <= cur_sp;
        evt_code <= req_code;
        sr_out   <= cur_sr | FORCE_MASK;
        new_pc   <= handler_pc;
      end
    end
  end

  // R7
  blocked_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && blocked) |=> (fatal && !done && $stable(saved_sr) && $stable(new_pc)));

  // R8
  fatal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && !done && $stable(saved_pc) && $stable(saved_sp) && $stable(evt_code)));

  // R2
  entry_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && !blocked) |=> (done && evt_code == $past(req_code)));

  // R4
  sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sr_out[SR_BLOCK_BIT] && sr_out[SR_BANK_BIT] && sr_out[SR_PRIV_BIT]));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!done && $stable(saved_sr) && $stable(sr_out)));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [XLEN-1:0]   req_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   vbr,
  output logic              done,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sp,
  output logic [CODE_W-1:0] evt_code,
  output logic              fatal
);
  exc_class_t      cls;
  logic [XLEN-1:0] handler_pc;
  logic            fire;

  assign req_ready = !fatal;
  assign fire      = req_valid && req_ready;

  exc_classify #(.CODE_W(CODE_W)) u_classify (
    .code (req_code),
    .cls  (cls)
  );

  exc_vector #(.XLEN(XLEN)) u_vector (
    .vbr        (vbr),
    .tlb_miss   (cls.tlb_miss),
    .handler_pc (handler_pc)
  );

  exc_commit #(.XLEN(XLEN), .CODE_W(CODE_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .legal      (cls.legal),
    .handler_pc (handler_pc),
    .req_code   (req_code),
    .req_pc     (req_pc),
    .cur_sr     (cur_sr),
    .cur_sp     (cur_sp),
    .done       (done),
    .new_pc     (new_pc),
    .sr_out     (sr_out),
    .saved_sr   (saved_sr),
    .saved_pc   (saved_pc),
    .saved_sp   (saved_sp),
    .evt_code   (evt_code),
    .fatal      (fatal)
  );

  // R6
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cls.legal) |=> (fatal && !done && $stable(evt_code)));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_code = '0;
  logic [31:0] req_pc = '0, cur_sr = '0, cur_sp = '0, vbr = '0;
  logic        done, fatal;
  logic [31:0] new_pc, sr_out, saved_sr, saved_pc, saved_sp;
  logic [11:0] evt_code;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_pc(req_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
    .vbr(vbr), .done(done), .new_pc(new_pc), .sr_out(sr_out),
    .saved_sr(saved_sr), .saved_pc(saved_pc), .saved_sp(saved_sp),
    .evt_code(evt_code), .fatal(fatal)
  );

  // {code, pc, sr, sp, vbr}
  localparam int NV = 8;
  localparam logic [139:0] VEC [NV] = '{
    {12'h040, 32'h0000_1000, 32'h0000_00F3, 32'h8C00_FFF0, 32'h8C00_0000},
    {12'h060, 32'h1234_5678, 32'h8FFF_FFFF, 32'h0000_0004, 32'hFFFF_FE00},
    {12'h100, 32'hA000_0002, 32'h0000_0001, 32'h7FFF_FFFC, 32'h0000_0000},
    {12'h1A0, 32'h0C00_0010, 32'h0F0F_0F0F, 32'h1111_1111, 32'h8000_0F00},
    {12'h800, 32'hDEAD_BEE0, 32'h8000_0000, 32'h2222_2222, 32'hFFFF_FF80},
    {12'h820, 32'h0000_0002, 32'h0000_00F0, 32'h3333_3333, 32'h0100_0000},
    {12'h1E0, 32'h4444_4444, 32'h8E00_0302, 32'h5555_5555, 32'h0200_0000},
    {12'h0E0, 32'h6666_6666, 32'h0000_0000, 32'h7777_7777, 32'h0300_0000}
  };

  function automatic logic [31:0] exp_pc(input logic [11:0] c, input logic [31:0] b);
    return b + (((c == 12'h040) || (c == 12'h060)) ? 32'h400 : 32'h100);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input logic [139:0] v);
    {req_code, req_pc, cur_sr, cur_sp, vbr} = v;
    req_valid = 1'b1;
  endtask

  task automatic check_entry(input string tag, input logic [139:0] v);
    logic [11:0] c; logic [31:0] p, s, sp, b;
    {c, p, s, sp, b} = v;
    check({tag, " R2 done"}, 32'(done), 32'd1);
    check({tag, " R2 evt_code"}, 32'(evt_code), 32'(c));
    check({tag, " R3 saved_sr"}, saved_sr, s);
    check({tag, " R3 saved_pc"}, saved_pc, p);
    check({tag, " R3 saved_sp"}, saved_sp, sp);
    check({tag, " R4 sr_out"}, sr_out, s | 32'h7000_0000);
    check({tag, " R5 new_pc"}, new_pc, exp_pc(c, b));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] hold_sr, hold_pc;
    do_reset();
    // R1 reset state
    check("R1 done", 32'(done), 0);
    check("R1 fatal", 32'(fatal), 0);
    check("R1 ready", 32'(req_ready), 1);
    check("R1 new_pc", new_pc, 0);
    check("R1 sr_out", sr_out, 0);
    check("R1 saved", saved_sr | saved_pc | saved_sp | 32'(evt_code), 0);

    // Table walk: R2..R6 legal codes
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req_valid = 1'b0;
      check_entry("table", VEC[i]);
      @(negedge clk);
      check("R2 single-cycle done", 32'(done), 0);
    end

    // R10 idle: inputs move, valid low
    hold_sr = saved_sr; hold_pc = new_pc;
    for (int k = 0; k < 3; k++) begin
      req_code = 12'h040; req_pc = 32'(k) * 32'h10; cur_sr = 32'h0000_00FF; vbr = 32'h1;
      @(negedge clk);
    end
    check("R10 idle done", 32'(done), 0);
    check("R10 idle saved_sr", saved_sr, hold_sr);
    check("R10 idle new_pc", new_pc, hold_pc);

    // R9 back-to-back
    drive(VEC[0]);
    @(negedge clk);
    check("R9 first done", 32'(done), 1);
    drive(VEC[3]);
    @(negedge clk);
    req_valid = 1'b0;
    check_entry("R9 second", VEC[3]);
    @(negedge clk);

    // R6 illegal codes below range, between range and 0x1E0, and far out
    begin
      logic [11:0] bad [3] = '{12'h020, 12'h1C0, 12'h2A0};
      for (int j = 0; j < 3; j++) begin
        do_reset();
        drive(VEC[2]);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_code = bad[j]; cur_sr = '0; req_pc = 32'hFFFF_0000; vbr = 32'h9000_0000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 illegal fatal", 32'(fatal), 1);
        check("R6 illegal no done", 32'(done), 0);
        check("R6 illegal keeps evt", 32'(evt_code), 32'h100);
        check("R6 illegal keeps pc", saved_pc, 32'hA000_0002);
      end
    end

    // R7 block bit set
    do_reset();
    drive(VEC[4]);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    drive(VEC[1]);
    cur_sr = 32'h1000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 blocked fatal", 32'(fatal), 1);
    check("R7 blocked no done", 32'(done), 0);
    check("R7 blocked keeps saved_sr", saved_sr, 32'h8000_0000);
    check("R7 blocked keeps new_pc", new_pc, 32'hFFFF_FF80 + 32'h100);

    // R8 sticky fatal, requests refused
    check("R8 ready low", 32'(req_ready), 0);
    drive(VEC[5]);
    repeat (3) @(negedge clk);
    check("R8 still fatal", 32'(fatal), 1);
    check("R8 ready stays low", 32'(req_ready), 0);
    check("R8 no done", 32'(done), 0);
    check("R8 saved_pc frozen", saved_pc, 32'hDEAD_BEE0);
    check("R8 evt frozen", 32'(evt_code), 32'h800);
    req_valid = 1'b0;

    // R1 reset clears fatal
    do_reset();
    check("R1 fatal cleared", 32'(fatal), 0);
    check("R1 ready after reset", 32'(req_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule